// File: doc/BRIEF.md
# EPROM Device Programming Sequencer

This block is the controller for programming a small serial EPROM microcontroller. On a start pulse it runs four whole-array passes, always in the same order. The first is a blank check at the minimum supply. The second programs every word at the programming supply. The third verifies every word at the minimum supply, and the fourth verifies every word at the maximum supply. It holds a shadow copy of the device address and drives the device through two single-cycle strobes. One strobe re-enters program mode, which selects the configuration word. The other advances the device address by one.

For each word, the sequencer either sends a read to the device and compares the returned word, or sends a request to an external per-word pulse engine and waits for that engine's pass or fail answer. A supply-select code goes to the programmable supply for each pass. The first failure stops the run and latches the failing pass and address. A complete run raises done without error.

The pass order and supply selection are:

| Pass | Index | Supply code |
|------|-------|-------------|
| Blank check | 0 | minimum |
| Program | 1 | programming |
| Verify low | 2 | minimum |
| Verify high | 3 | maximum |

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, busy, done, error, reenter, inc_addr, rd_req and pgm_req are 0, and vdd_code is 0. vdd_code is also 0 whenever the block is idle.
- R2: Every pass starts with a single-cycle reenter strobe. After it, dev_addr is all ones (11'h7FF), which is the configuration word. The first access of each pass is made at that word, and only then does the walk reach user address 0.
- R3: inc_addr is a single-cycle strobe that raises dev_addr by one. The last user address is 0x1FF when big_sel is 0 at start and 0x3FF when big_sel is 1. inc_addr is never issued at the last address, so the calibration area beyond it is never reached.
- R4: Passes run in the order blank(0), program(1), verify-low(2), verify-high(3). vdd_code is min(vmin_code,18) in passes 0 and 2, and min(vmax_code,18) in pass 3. In pass 1 it is vprog_code clamped to the range 10..14, which is 4.5 V to 5.5 V with code 0 meaning 2.0 V and 0.25 V per step.
- R5: In the blank check, each read word must equal 12'hFFF. A mismatch ends the run with error=1, fail_phase=0 and fail_addr set to the word's address.
- R6: In the program pass, each word issues one pgm_req and then waits for pgm_done. pgm_ok=0 ends the run with fail_phase=1 and the address of that word. pgm_req is never issued in any other pass.
- R7: In the verify passes, rd_data is compared with exp_data. A mismatch ends the run with fail_phase 2 or 3 and the address of that word.
- R8: A full run over N words (N = last+2) makes exactly 4 reenter strobes, N programming requests, 2N reads at the minimum code and N reads at the maximum code. It ends with done=1 and error=0. done and error hold until the next accepted start, and the cycle after that start shows busy=1 and done=0.
- R9: start has no effect while busy. This holds even in the cycle in which the final word's response arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| big_sel | input | 1 | 0: last user address 0x1FF, 1: 0x3FF |
| vmin_code | input | 5 | Minimum verify supply code |
| vmax_code | input | 5 | Maximum verify supply code |
| vprog_code | input | 5 | Programming supply code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (held) |
| error | output | 1 | Run ended on a failure (held) |
| fail_phase | output | 2 | Pass of the first failure |
| fail_addr | output | 11 | Address of the first failure (7FF = configuration) |
| vdd_code | output | 5 | Supply-select code |
| reenter | output | 1 | Mode re-entry strobe, selects configuration word |
| inc_addr | output | 1 | Address increment strobe |
| dev_addr | output | 11 | Shadow device address |
| rd_req | output | 1 | Read request for current word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 12 | Word read from device |
| exp_data | input | 12 | Expected word for dev_addr |
| pgm_req | output | 1 | Program request to pulse engine |
| pgm_done | input | 1 | Pulse engine finished |
| pgm_ok | input | 1 | Pulse engine result |

## Verification
Two events can land in the same cycle: the response for the final word of the verify-high pass and a new start request. The bench asserts start in exactly the cycle in which that read response is presented. It then confirms that the run finishes with done=1, that busy stays low afterwards, and that exactly four re-entry strobes were counted. A second start is also pulsed in the middle of a run, and the strobe count must again be four.

// File: rtl/epseq_pkg.sv
// Shared types and supply-code helpers for the EPROM programming sequencer.
// Assumes supply codes step 0.25 V from code 0 = 2.0 V.
package epseq_pkg;
    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_PROG  = 2'd1,
        PH_VLOW  = 2'd2,
        PH_VHIGH = 2'd3
    } phase_t;

    localparam int          VCODE_W  = 5;
    localparam logic [4:0]  VCODE_TOP = 5'd18;
    localparam logic [4:0]  VPROG_LO  = 5'd10;
    localparam logic [4:0]  VPROG_HI  = 5'd14;

    function automatic logic [VCODE_W-1:0] clamp_code(
        input logic [VCODE_W-1:0] c,
        input logic [VCODE_W-1:0] lo,
        input logic [VCODE_W-1:0] hi
    );
        if (c < lo)      return lo;
        else if (c > hi) return hi;
        else             return c;
    endfunction
endpackage

// File: rtl/seq_supply.sv
// Supply code selector: picks the code for the running pass and clamps
// it to the legal range. Outputs 0 while idle. Purely combinational.
module seq_supply
    import epseq_pkg::*;
(
    input  logic               active,
    input  phase_t             phase,
    input  logic [VCODE_W-1:0] vmin_code,
    input  logic [VCODE_W-1:0] vmax_code,
    input  logic [VCODE_W-1:0] vprog_code,
    output logic [VCODE_W-1:0] code
);
    // choose and clamp the code for the current pass
    always_comb begin
        code = '0;
        if (active) begin
            unique case (phase)
                PH_PROG:  code = clamp_code(vprog_code, VPROG_LO, VPROG_HI);
                PH_VHIGH: code = clamp_code(vmax_code, '0, VCODE_TOP);
                default:  code = clamp_code(vmin_code, '0, VCODE_TOP);
            endcase
        end
    end

    always_comb begin
        if (active) assert (code <= VCODE_TOP); // R4
    end
endmodule

// File: rtl/seq_addr.sv
// Shadow device address counter. A load selects the configuration word
// (all ones); a step adds one, so the configuration word wraps to 0x000.
// Assumes the device follows the same strobes one for one.
module seq_addr #(
    parameter int ADDR_W     = 11,
    parameter int LAST_SMALL = 'h1FF,
    parameter int LAST_LARGE = 'h3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic              step,
    input  logic              big_sel,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] CFG_IDX = '1;
    localparam logic [ADDR_W-1:0] LAST_S  = ADDR_W'(LAST_SMALL);
    localparam logic [ADDR_W-1:0] LAST_L  = ADDR_W'(LAST_LARGE);

    // track the device address
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= CFG_IDX;
        else if (load_cfg) addr <= CFG_IDX;
        else if (step)     addr <= addr + 1'b1;
    end

    // last user address for the selected array size
    assign at_last = (addr == (big_sel ? LAST_L : LAST_S));

    AST_CFG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_cfg |=> (addr == CFG_IDX)); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_cfg) |=> (addr == $past(addr) + 1'b1)); // R3
endmodule

// File: rtl/seq_check.sv
// Word compare unit: blank check expects all ones, verify passes expect
// the supplied word. Combinational; result is used only when data is valid.
module seq_check
    import epseq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  phase_t             phase,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic [DATA_W-1:0]  exp_data,
    output logic               mismatch
);
    // select reference word and compare
    always_comb begin
        if (phase == PH_BLANK) mismatch = (rd_data != {DATA_W{1'b1}});
        else                   mismatch = (rd_data != exp_data);
    end
endmodule

// File: rtl/eprom_prog_seq.sv
// Top sequencer: runs blank check, program, verify-low and verify-high
// passes over the configuration word and the user array, stopping on
// the first failure. Assumes the device answers each request exactly once.
module eprom_prog_seq
    import epseq_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 12,
    parameter int LAST_SMALL = 'h1FF,
    parameter int LAST_LARGE = 'h3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              big_sel,
    input  logic [4:0]        vmin_code,
    input  logic [4:0]        vmax_code,
    input  logic [4:0]        vprog_code,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        fail_phase,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [4:0]        vdd_code,
    output logic              reenter,
    output logic              inc_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic              pgm_req,
    input  logic              pgm_done,
    input  logic              pgm_ok
);
    typedef enum logic [2:0] {S_IDLE, S_ENTER, S_ISSUE, S_WAIT, S_STEP} st_t;

    st_t    state;
    phase_t phase;
    logic   big_q;
    logic   at_last;
    logic   mismatch;
    logic   resp;
    logic   word_bad;

    seq_addr #(.ADDR_W(ADDR_W), .LAST_SMALL(LAST_SMALL), .LAST_LARGE(LAST_LARGE)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_cfg(reenter), .step(inc_addr),
        .big_sel(big_q), .addr(dev_addr), .at_last(at_last)
    );

    seq_check #(.DATA_W(DATA_W)) u_chk (
        .phase(phase), .rd_data(rd_data), .exp_data(exp_data), .mismatch(mismatch)
    );

    seq_supply u_sup (
        .active(busy), .phase(phase), .vmin_code(vmin_code), .vmax_code(vmax_code),
        .vprog_code(vprog_code), .code(vdd_code)
    );

    // strobes and requests decoded from state
    assign busy     = (state != S_IDLE);
    assign reenter  = (state == S_ENTER);
    assign inc_addr = (state == S_STEP);
    assign rd_req   = (state == S_ISSUE) && (phase != PH_PROG);
    assign pgm_req  = (state == S_ISSUE) && (phase == PH_PROG);

    // response and failure for the word in flight
    assign resp     = (phase == PH_PROG) ? pgm_done : rd_valid;
    assign word_bad = (phase == PH_PROG) ? !pgm_ok  : mismatch;

    // pass sequencing, completion and failure latching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            phase      <= PH_BLANK;
            big_q      <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
            fail_phase <= '0;
            fail_addr  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state      <= S_ENTER;
                    phase      <= PH_BLANK;
                    big_q      <= big_sel;
                    done       <= 1'b0;
                    error      <= 1'b0;
                    fail_phase <= '0;
                    fail_addr  <= '0;
                end
                S_ENTER: state <= S_ISSUE;
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (resp) begin
                    if (word_bad) begin
                        state      <= S_IDLE;
                        done       <= 1'b1;
                        error      <= 1'b1;
                        fail_phase <= phase;
                        fail_addr  <= dev_addr;
                    end else if (at_last) begin
                        if (phase == PH_VHIGH) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            phase <= phase_t'(phase + 2'd1);
                            state <= S_ENTER;
                        end
                    end else begin
                        state <= S_STEP;
                    end
                end
                S_STEP: state <= S_ISSUE;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        inc_addr |=> !inc_addr); // R3
    AST_NO_CALIB: assert property (@(posedge clk) disable iff (!rst_n)
        inc_addr |-> !at_last); // R3
    AST_REENTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reenter |=> !reenter); // R2
    AST_PGM_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> (vdd_code >= VPROG_LO && vdd_code <= VPROG_HI)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done); // R8
    AST_IDLE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (vdd_code == '0)); // R1
endmodule

// File: tb/sim_eprom_prog_seq.sv
module sim_eprom_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int WD_LIMIT = 195000;

    // vector: big, vmin, vmax, vprog, fault kind, fault addr, exp err, exp phase
    localparam logic [32:0] VEC [0:NVEC-1] = '{
        {1'b0, 5'd10, 5'd14, 5'd12, 3'd0, 11'h000, 1'b0, 2'd0},
        {1'b0, 5'd0,  5'd18, 5'd20, 3'd0, 11'h000, 1'b0, 2'd0},
        {1'b0, 5'd8,  5'd16, 5'd12, 3'd1, 11'h100, 1'b1, 2'd0},
        {1'b0, 5'd8,  5'd16, 5'd12, 3'd1, 11'h7FF, 1'b1, 2'd0},
        {1'b0, 5'd8,  5'd16, 5'd12, 3'd2, 11'h1FF, 1'b1, 2'd1},
        {1'b0, 5'd8,  5'd16, 5'd12, 3'd3, 11'h005, 1'b1, 2'd2},
        {1'b0, 5'd8,  5'd16, 5'd12, 3'd4, 11'h7FF, 1'b1, 2'd3},
        {1'b1, 5'd8,  5'd25, 5'd3,  3'd0, 11'h000, 1'b0, 2'd0}
    };

    logic clk = 0, rst_n = 0, start_t = 0, coll_start = 0, big_sel = 0;
    logic start;
    logic [4:0] vmin_code = 0, vmax_code = 0, vprog_code = 0;
    logic busy, done, error, reenter, inc_addr, rd_req, pgm_req;
    logic [1:0] fail_phase;
    logic [10:0] fail_addr, dev_addr;
    logic [4:0] vdd_code;
    logic rd_valid = 0, pgm_done = 0, pgm_ok = 0;
    logic [11:0] rd_data = 0;
    logic [11:0] exp_data;

    assign start = start_t | coll_start;

    eprom_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .big_sel(big_sel),
        .vmin_code(vmin_code), .vmax_code(vmax_code), .vprog_code(vprog_code),
        .busy(busy), .done(done), .error(error), .fail_phase(fail_phase),
        .fail_addr(fail_addr), .vdd_code(vdd_code), .reenter(reenter),
        .inc_addr(inc_addr), .dev_addr(dev_addr), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .exp_data(exp_data),
        .pgm_req(pgm_req), .pgm_done(pgm_done), .pgm_ok(pgm_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic wd = 0;

    // device model state
    logic [10:0] pc = 11'h7FF;
    logic [11:0] mem [0:1025];
    logic        wrt [0:1025];
    logic [1:0]  pcnt = 0;
    logic [10:0] last_a = 11'h1FF;
    logic [2:0]  fkind = 0;
    logic [10:0] faddr = 0;
    logic [4:0]  vminc = 0, vmaxc = 0, vprogc = 0;
    logic        coll_en = 0, exp_cfg = 0;
    int n_enter = 0, n_pgm = 0, n_rlow = 0, n_rhigh = 0;
    int calib = 0, cfg_bad = 0, vprog_bad = 0;

    function automatic int idx(input logic [10:0] a);
        return (a == 11'h7FF) ? 0 : int'(a) + 1;
    endfunction

    function automatic logic [11:0] pattern(input logic [10:0] a);
        return {1'b0, a} ^ 12'h5A3;
    endfunction

    assign exp_data = pattern(pc);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) wd <= 1;
    end

    // device and pulse engine model
    always @(posedge clk) begin
        rd_valid <= 0;
        pgm_done <= 0;
        coll_start <= 0;
        if (reenter) begin pc <= 11'h7FF; n_enter <= n_enter + 1; exp_cfg <= 1; end
        else if (inc_addr) begin
            if (pc == last_a) calib <= calib + 1;
            pc <= pc + 1;
        end
        if (rd_req || pgm_req) begin
            if (exp_cfg && pc != 11'h7FF) cfg_bad <= cfg_bad + 1;
            exp_cfg <= 0;
        end
        if (rd_req) begin
            logic [11:0] v;
            v = mem[idx(pc)];
            if (wrt[idx(pc)] && pc == faddr &&
                ((fkind == 3 && vdd_code == vminc) || (fkind == 4 && vdd_code == vmaxc)))
                v = v ^ 12'h001;
            rd_valid <= 1;
            rd_data <= v;
            if (vdd_code == vminc) n_rlow <= n_rlow + 1;
            if (vdd_code == vmaxc) n_rhigh <= n_rhigh + 1;
            if (coll_en && pc == last_a && vdd_code == vmaxc && wrt[idx(pc)]) coll_start <= 1;
        end
        if (pgm_req) begin
            pcnt <= 2;
            n_pgm <= n_pgm + 1;
            if (vdd_code != vprogc) vprog_bad <= vprog_bad + 1;
        end else if (pcnt != 0) begin
            pcnt <= pcnt - 1;
            if (pcnt == 1) begin
                pgm_done <= 1;
                pgm_ok <= !(fkind == 2 && pc == faddr);
                if (!(fkind == 2 && pc == faddr)) begin
                    mem[idx(pc)] <= pattern(pc);
                    wrt[idx(pc)] <= 1;
                end
            end
        end
    end

    task automatic run(input int i, input bit mid);
        logic [32:0] v;
        int nw;
        v = VEC[i];
        big_sel = v[32]; vmin_code = v[31:27]; vmax_code = v[26:22]; vprog_code = v[21:17];
        fkind = v[16:14]; faddr = v[13:3];
        last_a = v[32] ? 11'h3FF : 11'h1FF;
        vminc = (v[31:27] > 18) ? 5'd18 : v[31:27];
        vmaxc = (v[26:22] > 18) ? 5'd18 : v[26:22];
        vprogc = (v[21:17] < 10) ? 5'd10 : (v[21:17] > 14) ? 5'd14 : v[21:17];
        for (int k = 0; k < 1026; k++) begin mem[k] = 12'hFFF; wrt[k] = 0; end
        if (fkind == 1) mem[idx(faddr)] = 12'h000;
        n_enter = 0; n_pgm = 0; n_rlow = 0; n_rhigh = 0; calib = 0; cfg_bad = 0; vprog_bad = 0;
        start_t = 1;
        @(negedge clk);
        start_t = 0;
        @(negedge clk);
        chk(busy == 1 && done == 0, "R8 start clears done", int'(done), 0);
        if (mid) begin
            repeat (40) @(negedge clk);
            start_t = 1; @(negedge clk); start_t = 0;
        end
        while (!done && !wd) @(negedge clk);
        repeat (3) @(negedge clk);
        nw = int'(last_a) + 2;
        chk(error == v[2], "R5/R6/R7 error flag", int'(error), int'(v[2]));
        chk(done == 1 && busy == 0, "R8 done held", int'(done), 1);
        chk(calib == 0, "R3 no calibration access", calib, 0);
        chk(cfg_bad == 0, "R2 pass starts at config", cfg_bad, 0);
        chk(vprog_bad == 0, "R4 programming code", vprog_bad, 0);
        if (v[2]) begin
            chk(fail_phase == v[1:0], "R5/R6/R7 fail phase", int'(fail_phase), int'(v[1:0]));
            chk(fail_addr == faddr, "R5/R6/R7 fail addr", int'(fail_addr), int'(faddr));
        end else begin
            chk(n_enter == 4, "R2 R9 reenter count", n_enter, 4);
            chk(n_pgm == nw, "R6 program count", n_pgm, nw);
            chk(n_rlow == 2 * nw, "R4 low reads", n_rlow, 2 * nw);
            chk(n_rhigh == nw, "R4 high reads", n_rhigh, nw);
            chk(vdd_code == 0, "R1 idle supply", int'(vdd_code), 0);
        end
    endtask

    initial begin
        for (int k = 0; k < 1026; k++) begin mem[k] = 12'hFFF; wrt[k] = 0; end
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0, "R1 reset flags", int'(busy), 0);
        chk(reenter == 0 && inc_addr == 0 && rd_req == 0 && pgm_req == 0,
            "R1 reset strobes", int'(inc_addr), 0);
        chk(vdd_code == 0, "R1 reset supply", int'(vdd_code), 0);
        rst_n = 1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            if (!wd) begin
                coll_en = (i == 1);
                run(i, i == 0);
                coll_en = 0;
            end
        end
        // R9: collision case left the block idle after the last response
        repeat (5) @(negedge clk);
        chk(busy == 0, "R9 start ignored while busy", int'(busy), 0);
        // R1: reset in mid-run returns to idle
        start_t = 1; @(negedge clk); start_t = 0;
        repeat (20) @(negedge clk);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        chk(busy == 0 && done == 0 && vdd_code == 0, "R1 reset mid-run", int'(busy), 0);
        if (wd) chk(0, "watchdog", cycles, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule